// File: doc/BRIEF.md
# Strided Stream Window Controller

This block keeps a long stream of records flowing through a small ring of storage slots. Software starts it with a base address, a stride, a record count and a direction. Record k of the stream sits at base + k × stride. Only a few records are held at once. Each retired element-advance event takes the oldest record (the head) out of the ring, and that frees a slot for one more record at the tail.

For a read stream, the controller fetches records ahead of use until the ring is full, or until the whole stream has been requested. The head record is shown on `headData` while `headValid` is high, and an advance discards it. For a write stream, a start only reserves slots and makes no memory traffic. The producer writes the head record through `wrEn`/`wrData`. An advance queues that record for a store to memory. A flush command then stores every record still held in the ring. The memory side has a valid/ready request channel and an in-order response channel that returns read data.

Top module: `swin_stream_ctrl`

## Requirements
- R1: After reset, and before the first start, `memReqValid`, `headValid` and `done` are all low.
- R2: Each run's memory requests go out in ascending record order. The k-th request of a run (counted from 0) carries address base + k × stride modulo 2^ADDR_W. `memReqWrite` is 0 for a read stream (`cfgOut`=0) and 1 for a write stream (`cfgOut`=1).
- R3: A read stream with no advances requests exactly min(WIN, length) records and then stops. Once the first response arrives, `headValid` is high.
- R4: In a read stream, records requested but not yet advanced never exceed WIN. No request goes beyond the programmed length, and every record is requested exactly once.
- R5: In a read stream, the n-th accepted advance consumes record n. During that advance, `headData` equals the response data returned for record n.
- R6: An advance given while `headValid` is low has no effect. Later heads still present records in order with no record skipped.
- R7: A write stream makes no memory request until the first advance. `headValid` rises when the length is nonzero.
- R8: In a write stream, each accepted advance queues the head record for a store. The store carries the last value written with `wrEn` while that record was the head. No record is stored before it has been advanced.
- R9: A flush on a write stream stores every remaining reserved record, in order after the records already advanced, with min(length, advanced + WIN) records stored in total. After the flush, `headValid` stays low.
- R10: `done` rises when the last record has been consumed (read stream), stored (write stream) or drained after a flush. It stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load configuration and begin a new stream |
| cfgOut | input | 1 | Direction: 0 read stream, 1 write stream |
| cfgBase | input | ADDR_W | Address of record 0 |
| cfgStride | input | ADDR_W | Address step between records |
| cfgLen | input | LEN_W | Number of records in the stream |
| advance | input | 1 | Retired element-advance event |
| flush | input | 1 | Store all remaining records (write stream) |
| wrEn | input | 1 | Write `wrData` into the head record |
| wrData | input | DATA_W | Head record write data |
| headValid | output | 1 | Head record is present |
| headData | output | DATA_W | Head record contents |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | Request is a store |
| memReqAddr | output | ADDR_W | Request address |
| memReqData | output | DATA_W | Store data |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read response valid (in order) |
| memRspData | input | DATA_W | Read response data |
| done | output | 1 | Stream finished |

## Verification
Two cases are hard to reach from the ports. The first is a flush that lands while the ring holds reserved records that were never advanced. The second is an advance that arrives while the head is still waiting for its response. For the first, the stimulus stops advancing at a chosen record and waits long enough for the earlier stores to drain and the tail to refill. It then flushes and counts the trailing stores against min(length, advanced + WIN). For the second, the bench throttles responses and readiness with a pseudo-random pattern and gives advances regardless of `headValid`. A skipped or repeated record then appears as an address or data mismatch, because every address and data value is computed arithmetically from the base, the stride and the record number.

// File: rtl/swin_pkg.sv
package swin_pkg;
  // Strobes from the control path to the datapath, one per event.
  typedef struct packed {
    logic load;       // capture configuration
    logic allocStep;  // a tail record is requested or reserved
    logic rspCapture; // read response lands in its slot
    logic drainStep;  // head leaves (read) or a store is accepted (write)
    logic wrHead;     // producer writes the head slot
  } swinStrobe_t;
endpackage

// File: rtl/swin_ctrl.sv
module swin_ctrl
  import swin_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int WIN    = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgOut,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              advance,
  input  logic              flush,
  input  logic              wrEn,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output swinStrobe_t       strb,
  output logic [SLOT_W-1:0] fillSlot,
  output logic [SLOT_W-1:0] headSlot,
  output logic [SLOT_W-1:0] drainSlot,
  output logic              outMode,
  output logic              headValid,
  output logic              memReqValid,
  output logic              done
);
  localparam logic [LEN_W-1:0] WIN_L = LEN_W'(WIN);

  logic             active, flushed;
  logic [LEN_W-1:0] lenReg;
  // Record counters: requested/reserved, arrived, advanced, written back.
  logic [LEN_W-1:0] allocIdx, readyIdx, headIdx, drainIdx;

  logic [LEN_W-1:0] occ, drainLimit;
  logic             allocOpen, storePend, fetchPend, headStep, flushHit;

  always_comb begin
    occ        = allocIdx - drainIdx;
    allocOpen  = active && !flushed && (allocIdx != lenReg) && (occ < WIN_L);
    drainLimit = flushed ? allocIdx : headIdx;
    storePend  = active && outMode && (drainIdx != drainLimit);
    fetchPend  = !outMode && allocOpen;
    headValid  = active && !flushed && (readyIdx != headIdx);
    headStep   = advance && headValid;
    flushHit   = active && outMode && flush && !flushed;

    strb.load       = start;
    strb.allocStep  = outMode ? allocOpen : (fetchPend && memReqReady);
    strb.rspCapture = active && !outMode && memRspValid && (readyIdx != allocIdx);
    strb.drainStep  = outMode ? (storePend && memReqReady) : headStep;
    strb.wrHead     = outMode && wrEn && headValid;
  end

  assign memReqValid = storePend || fetchPend;
  assign fillSlot    = readyIdx[SLOT_W-1:0];
  assign headSlot    = headIdx[SLOT_W-1:0];
  assign drainSlot   = drainIdx[SLOT_W-1:0];
  assign done = active && (outMode ? (drainIdx == (flushed ? allocIdx : lenReg))
                                   : (headIdx == lenReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      outMode  <= 1'b0;
      flushed  <= 1'b0;
      lenReg   <= '0;
      allocIdx <= '0;
      readyIdx <= '0;
      headIdx  <= '0;
      drainIdx <= '0;
    end else if (start) begin
      active   <= 1'b1;
      outMode  <= cfgOut;
      flushed  <= 1'b0;
      lenReg   <= cfgLen;
      allocIdx <= '0;
      readyIdx <= '0;
      headIdx  <= '0;
      drainIdx <= '0;
    end else begin
      if (strb.allocStep) allocIdx <= allocIdx + 1'b1;
      // Write-stream slots count as present as soon as they are reserved.
      if (outMode ? strb.allocStep : strb.rspCapture) readyIdx <= readyIdx + 1'b1;
      if (headStep)       headIdx  <= headIdx + 1'b1;
      if (strb.drainStep) drainIdx <= drainIdx + 1'b1;
      if (flushHit)       flushed  <= 1'b1;
    end
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (allocIdx - drainIdx) <= WIN_L);                        // R4
  AST_ALLOC_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    active |-> allocIdx <= lenReg);                                     // R4
  AST_HEAD_BEHIND_DATA: assert property (@(posedge clk) disable iff (!rstN)
    headIdx <= readyIdx);                                               // R6
  AST_STORE_AFTER_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (active && outMode && !flushed) |-> drainIdx <= headIdx);           // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);                                         // R10
endmodule

// File: rtl/swin_dpath.sv
module swin_dpath
  import swin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WIN    = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  swinStrobe_t       strb,
  input  logic              outMode,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgStride,
  input  logic [SLOT_W-1:0] fillSlot,
  input  logic [SLOT_W-1:0] headSlot,
  input  logic [SLOT_W-1:0] drainSlot,
  input  logic [DATA_W-1:0] memRspData,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  output logic [DATA_W-1:0] headData
);
  logic [ADDR_W-1:0] strideReg, allocAddr, drainAddr;
  logic [DATA_W-1:0] slotMem [WIN];

  // Running addresses avoid a multiplier: each step adds the stride.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strideReg <= '0;
      allocAddr <= '0;
      drainAddr <= '0;
    end else if (strb.load) begin
      strideReg <= cfgStride;
      allocAddr <= cfgBase;
      drainAddr <= cfgBase;
    end else begin
      if (strb.allocStep) allocAddr <= allocAddr + strideReg;
      if (strb.drainStep) drainAddr <= drainAddr + strideReg;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.rspCapture) slotMem[fillSlot] <= memRspData;
    if (strb.wrHead)     slotMem[headSlot] <= wrData;
  end

  assign memReqAddr = outMode ? drainAddr : allocAddr;
  assign memReqData = slotMem[drainSlot];
  assign headData   = slotMem[headSlot];
endmodule

// File: rtl/swin_stream_ctrl.sv
module swin_stream_ctrl
  import swin_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 6,
  parameter int WIN_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgOut,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgStride,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              advance,
  input  logic              flush,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              headValid,
  output logic [DATA_W-1:0] headData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              done
);
  localparam int SLOT_W = (WIN_SLOTS > 1) ? $clog2(WIN_SLOTS) : 1;

  swinStrobe_t       strb;
  logic [SLOT_W-1:0] fillSlot, headSlot, drainSlot;
  logic              outMode;

  swin_ctrl #(.LEN_W(LEN_W), .WIN(WIN_SLOTS), .SLOT_W(SLOT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgOut(cfgOut), .cfgLen(cfgLen),
    .advance(advance), .flush(flush), .wrEn(wrEn), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .strb(strb), .fillSlot(fillSlot),
    .headSlot(headSlot), .drainSlot(drainSlot), .outMode(outMode),
    .headValid(headValid), .memReqValid(memReqValid), .done(done)
  );

  swin_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN(WIN_SLOTS), .SLOT_W(SLOT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .outMode(outMode), .cfgBase(cfgBase),
    .cfgStride(cfgStride), .fillSlot(fillSlot), .headSlot(headSlot),
    .drainSlot(drainSlot), .memRspData(memRspData), .wrData(wrData),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .headData(headData)
  );

  assign memReqWrite = outMode;
endmodule

// File: tb/tb_swin_stream_ctrl.sv
`timescale 1ns/1ps
module tb_swin_stream_ctrl;
  localparam int WIN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, cfgOut = 1'b0;
  logic [15:0] cfgBase = '0, cfgStride = '0;
  logic [5:0]  cfgLen = '0;
  logic        advance = 1'b0, flush = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        headValid, memReqValid, memReqWrite, done;
  logic [15:0] headData, memReqAddr, memReqData;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [15:0] memRspData = '0;

  swin_stream_ctrl dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgOut(cfgOut), .cfgBase(cfgBase),
    .cfgStride(cfgStride), .cfgLen(cfgLen), .advance(advance), .flush(flush),
    .wrEn(wrEn), .wrData(wrData), .headValid(headValid), .headData(headData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .done(done)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] fifoAddr [64];
  int fifoWr = 0, fifoRd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] recAddr(input int base, input int stride, input int k);
    return 16'(base + k * stride);
  endfunction
  function automatic logic [15:0] rdVal(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] wrVal(input int i);
    return 16'(i * 37 + 256);
  endfunction

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic runStream(input bit dirOut, input int len, input int stride,
                           input int base, input int flushAt);
    int reqCnt = 0, cons = 0, stCnt = 0, cyc = 0, waitCnt = 0, flushTarget = 0;
    bit flushedTb = 0, sentFlush = 0, skipped = 0, hvChecked = 0, expDone;
    fifoWr = 0; fifoRd = 0;
    @(negedge clk);
    start = 1'b1; cfgOut = dirOut; cfgLen = 6'(len);
    cfgBase = 16'(base); cfgStride = 16'(stride);
    @(negedge clk);
    start = 1'b0;
    forever begin
      expDone = dirOut ? (flushedTb ? (stCnt == flushTarget) : (stCnt == len))
                       : (cons == len);
      chk(done == expDone, "R10 done", int'(done), int'(expDone));
      if (cyc >= 20 && expDone && fifoRd == fifoWr) break;
      if (cyc > 3000) begin
        chk(1'b0, "R10 run did not finish", cyc, 3000);
        break;
      end
      stepLfsr();
      memReqReady = (cyc < 20) ? 1'b1 : (lfsr[1:0] != 2'b00);
      memRspValid = (fifoRd != fifoWr) && ((cyc < 20) || lfsr[2] || lfsr[5]);
      memRspData  = rdVal(fifoAddr[fifoRd % 64]);
      advance = (cyc >= 20) && lfsr[3] && !(flushAt >= 0 && cons >= flushAt);
      wrEn = dirOut; wrData = wrVal(cons);
      flush = 1'b0;
      if (flushAt >= 0 && cons >= flushAt && !sentFlush && cyc >= 20) begin
        waitCnt++;
        if (waitCnt > 30) begin flush = 1'b1; sentFlush = 1; end
      end
      #1;
      if (cyc == 19) begin
        if (!dirOut) begin
          chk(reqCnt == ((len < WIN) ? len : WIN), "R3 prefetch count", reqCnt,
              (len < WIN) ? len : WIN);
          chk(headValid == (len > 0), "R3 head after prefetch", int'(headValid), int'(len > 0));
        end else begin
          chk(stCnt == 0 && !memReqValid, "R7 no traffic on allocate", stCnt, 0);
          chk(headValid == (len > 0), "R7 head reserved", int'(headValid), int'(len > 0));
        end
      end
      if (flushedTb && !hvChecked) begin
        chk(!headValid, "R9 head hidden after flush", int'(headValid), 0);
        hvChecked = 1;
      end
      if (memReqValid && memReqReady) begin
        if (!dirOut) begin
          chk(!memReqWrite, "R2 read kind", int'(memReqWrite), 0);
          chk(memReqAddr == recAddr(base, stride, reqCnt), "R2 fetch address",
              int'(memReqAddr), int'(recAddr(base, stride, reqCnt)));
          chk(reqCnt < len && (reqCnt - cons) < WIN, "R4 fetch bound", reqCnt - cons, WIN);
          fifoAddr[fifoWr % 64] = memReqAddr;
          fifoWr++;
          reqCnt++;
        end else begin
          chk(memReqWrite, "R2 store kind", int'(memReqWrite), 1);
          chk(memReqAddr == recAddr(base, stride, stCnt), "R2 store address",
              int'(memReqAddr), int'(recAddr(base, stride, stCnt)));
          if (!flushedTb) begin
            chk(stCnt < cons, "R8 store after advance", stCnt, cons);
            chk(memReqData == wrVal(stCnt), "R8 store data", int'(memReqData), int'(wrVal(stCnt)));
          end else begin
            chk(stCnt < flushTarget, "R9 flush store count", stCnt, flushTarget);
            if (stCnt <= flushAt)
              chk(memReqData == wrVal(stCnt), "R9 flushed data", int'(memReqData),
                  int'(wrVal(stCnt)));
          end
          stCnt++;
        end
      end
      if (memRspValid) fifoRd++;
      if (advance && !headValid) skipped = 1;
      if (advance && headValid) begin
        if (!dirOut) begin
          chk(headData == rdVal(recAddr(base, stride, cons)), skipped ? "R6 head order" : "R5 head data",
              int'(headData), int'(rdVal(recAddr(base, stride, cons))));
          skipped = 0;
        end
        cons++;
      end
      if (flush) begin
        flushedTb = 1;
        flushTarget = (len < cons + WIN) ? len : cons + WIN;
      end
      cyc++;
      @(negedge clk);
    end
    advance = 1'b0; flush = 1'b0; wrEn = 1'b0; memRspValid = 1'b0;
    if (!dirOut) chk(reqCnt == len, "R4 all records fetched once", reqCnt, len);
    else if (flushAt < 0) chk(stCnt == len, "R8 all records stored", stCnt, len);
    else chk(stCnt == flushTarget, "R9 flush total", stCnt, flushTarget);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [6] = '{0, 1, 3, 4, 5, 11};
    int strides [3] = '{1, 6, 16'hFFF8};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!memReqValid, "R1 reset request", int'(memReqValid), 0);
    chk(!headValid, "R1 reset head", int'(headValid), 0);
    chk(!done, "R1 reset done", int'(done), 0);
    for (int d = 0; d < 2; d++)
      for (int l = 0; l < 6; l++)
        for (int s = 0; s < 3; s++)
          runStream(d[0], lens[l], strides[s], 16'h1000 + l * 16'h0123, -1);
    runStream(1'b1, 11, 6, 16'h2000, 2);
    runStream(1'b1, 3, 1, 16'h0040, 1);
    runStream(1'b1, 9, 16'hFFF8, 16'h0008, 6);
    runStream(1'b1, 5, 3, 16'h3000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule